// File: doc/BRIEF.md
# Free-Block Feedback Share Allocator

This block sets the two weights that a fair-share request scheduler uses to divide flash bandwidth between host traffic and garbage collection. The only measure of system state it looks at is the number of free blocks. That count is compared with a programmable goal. When free space falls short of the goal, the garbage-collection weight rises in proportion to the shortfall, so reclaiming speeds up before writes stall. When free space meets or exceeds the goal, the host weight dominates.

The weights are recomputed only when an update strobe is high, and they hold their values between strobes. The shortfall is the goal minus the current count, and it is floored at zero. The garbage-collection weight is a base value plus a gain times the shortfall. That result is clamped to a fixed window, and the host weight is the full share minus the garbage-collection weight. Both weights come from registers. After reset the split is even.

Top module: `free_share_alloc`

## Requirements
- R1: While `rst` is high at a clock edge, both `gc_share` and `host_share` read 50 after that edge.
- R2: After reset, `host_share + gc_share` equals 100 in every cycle.
- R3: When a strobe samples `free_cnt >= target_cnt`, the garbage-collection weight becomes the base value of 20 and the host weight becomes 80.
- R4: When a strobe samples a shortfall d = `target_cnt - free_cnt` > 0, `gc_share` becomes 20 + 4*d if that value lies within 10..90. For example, d=1 gives 24, d=5 gives 40 and d=17 gives 88.
- R5: A shortfall whose linear result would exceed 90 gives `gc_share` = 90 and `host_share` = 10. This holds up to the largest shortfall the count width allows, with no wraparound.
- R6: `gc_share` always stays within 10..90 outside reset.
- R7: In a cycle where `upd_stb` is low, the outputs keep their previous values, whatever `free_cnt` and `target_cnt` do.
- R8: A strobe sampled at clock edge k changes the outputs right after edge k, not before it. The inputs used are those present at edge k.
- R9: A larger shortfall never gives a smaller `gc_share`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_stb | input | 1 | Recompute the weights at this edge |
| free_cnt | input | CNT_W (16) | Current number of free blocks |
| target_cnt | input | CNT_W (16) | Desired number of free blocks |
| host_share | output | 8 | Host weight, in percent |
| gc_share | output | 8 | Garbage-collection weight, in percent |

## Verification
Every result is due exactly one edge after the strobe or reset that causes it, because the only register is the output register. The bench drives inputs at the falling edge and holds a behavioural model that updates on each rising edge. It compares both weights with the model at every falling edge, so each strobe is checked half a cycle after it takes effect. Directed checks at that same falling edge confirm literal values, the clamp limits and the ordering across a sweep of shortfalls. One check just after a strobe is driven, and before its edge, confirms that the old values still stand.

// File: rtl/qa_share_pkg.sv
package qa_share_pkg;

    localparam int SHARE_W    = 8;
    localparam int SHARE_FULL = 100;

    typedef logic [SHARE_W-1:0] share_t;

    typedef struct packed {
        share_t host;
        share_t gc;
    } share_pair_t;

    // Build a weight pair whose two halves always add to the full share.
    function automatic share_pair_t pair_from_gc(input share_t gc);
        share_pair_t p;
        p.gc   = gc;
        p.host = share_t'(SHARE_FULL) - gc;
        return p;
    endfunction

endpackage

// File: rtl/share_deficit.sv
module share_deficit #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [CNT_W-1:0] target_cnt,
    output logic [CNT_W-1:0] deficit
);

    always_comb begin
        if (target_cnt > free_cnt) begin
            deficit = target_cnt - free_cnt;
        end else begin
            deficit = '0;
        end
    end

endmodule

// File: rtl/share_map.sv
module share_map
    import qa_share_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAIN   = 4,
    parameter int BASE   = 20,
    parameter int GC_MIN = 10,
    parameter int GC_MAX = 90
) (
    input  logic [CNT_W-1:0] deficit,
    output share_pair_t      shares
);

    localparam int GAIN_W  = $clog2(GAIN + 1);
    localparam int RAW_W   = CNT_W + GAIN_W + SHARE_W + 1;
    localparam bit GAIN_P2 = (GAIN > 0) && ((GAIN & (GAIN - 1)) == 0);

    localparam logic [RAW_W-1:0] BASE_R = RAW_W'(BASE);
    localparam logic [RAW_W-1:0] MIN_R  = RAW_W'(GC_MIN);
    localparam logic [RAW_W-1:0] MAX_R  = RAW_W'(GC_MAX);

    logic [RAW_W-1:0] scaled;
    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] bounded;

    generate
        if (GAIN_P2) begin : g_shift
            localparam int SH = $clog2(GAIN);
            assign scaled = RAW_W'(deficit) << SH;
        end else begin : g_mult
            assign scaled = RAW_W'(deficit) * RAW_W'(GAIN);
        end
    endgenerate

    assign raw = BASE_R + scaled;

    always_comb begin
        if (raw > MAX_R) begin
            bounded = MAX_R;
        end else if (raw < MIN_R) begin
            bounded = MIN_R;
        end else begin
            bounded = raw;
        end
    end

    assign shares = pair_from_gc(share_t'(bounded));

endmodule

// File: rtl/share_hold_reg.sv
module share_hold_reg
    import qa_share_pkg::*;
#(
    parameter int RST_GC = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_stb,
    input  share_pair_t d,
    output share_pair_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= pair_from_gc(share_t'(RST_GC));
        end else if (upd_stb) begin
            q <= d;
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (q.gc == share_t'(RST_GC)) && (q.host == share_t'(SHARE_FULL - RST_GC)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> $stable(q));

    // R8
    strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> (q == $past(d)));

endmodule

// File: rtl/free_share_alloc.sv
module free_share_alloc
    import qa_share_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAIN   = 4,
    parameter int BASE   = 20,
    parameter int GC_MIN = 10,
    parameter int GC_MAX = 90,
    parameter int RST_GC = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_stb,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [CNT_W-1:0] target_cnt,
    output logic [7:0]       host_share,
    output logic [7:0]       gc_share
);

    localparam int BASE_CLAMP = (BASE > GC_MAX) ? GC_MAX : ((BASE < GC_MIN) ? GC_MIN : BASE);

    logic [CNT_W-1:0] deficit;
    share_pair_t      next_shares;
    share_pair_t      cur_shares;

    share_deficit #(.CNT_W(CNT_W)) u_deficit (
        .free_cnt   (free_cnt),
        .target_cnt (target_cnt),
        .deficit    (deficit)
    );

    share_map #(
        .CNT_W  (CNT_W),
        .GAIN   (GAIN),
        .BASE   (BASE),
        .GC_MIN (GC_MIN),
        .GC_MAX (GC_MAX)
    ) u_map (
        .deficit (deficit),
        .shares  (next_shares)
    );

    share_hold_reg #(.RST_GC(RST_GC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .upd_stb (upd_stb),
        .d       (next_shares),
        .q       (cur_shares)
    );

    assign host_share = cur_shares.host;
    assign gc_share   = cur_shares.gc;

    // R2
    sum_full_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, host_share} + {1'b0, gc_share}) == 9'(SHARE_FULL));

    // R6
    gc_range_chk: assert property (@(posedge clk) disable iff (rst)
        (gc_share >= 8'(GC_MIN)) && (gc_share <= 8'(GC_MAX)));

    // R3
    plentiful_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && (free_cnt >= target_cnt)) |=> (gc_share == 8'(BASE_CLAMP)));

endmodule

// File: tb/free_share_alloc_bench.sv
module free_share_alloc_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_stb = 1'b0;
    logic [15:0] free_cnt = '0;
    logic [15:0] target_cnt = '0;
    logic [7:0]  host_share;
    logic [7:0]  gc_share;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string cur_tag = "R1";

    int m_gc = 50;

    always #(CLK_PERIOD/2) clk = ~clk;

    free_share_alloc u_free_share_alloc (
        .clk        (clk),
        .rst        (rst),
        .upd_stb    (upd_stb),
        .free_cnt   (free_cnt),
        .target_cnt (target_cnt),
        .host_share (host_share),
        .gc_share   (gc_share)
    );

    function automatic int ref_gc(input int fr, input int tg);
        int d;
        int r;
        d = (tg > fr) ? (tg - fr) : 0;
        r = 20 + 4 * d;
        if (r > 90) r = 90;
        if (r < 10) r = 10;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, one register deep.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) m_gc <= 50;
        else if (upd_stb) m_gc <= ref_gc(int'(free_cnt), int'(target_cnt));
    end

    // Compare with the reference on every clock.
    always @(negedge clk) begin
        if (!finished) begin
            check({cur_tag, " gc vs model"}, int'(gc_share), m_gc);
            check("R2 host vs model", int'(host_share), 100 - m_gc);
            if (!rst) begin
                check("R6 gc range", int'((gc_share >= 10) && (gc_share <= 90)), 1);
            end
        end
    end

    task automatic drive(input bit stb, input int fr, input int tg);
        @(negedge clk);
        upd_stb    = stb;
        free_cnt   = 16'(fr);
        target_cnt = 16'(tg);
    endtask

    task automatic expect_gc(input string tag, input int exp);
        @(negedge clk);
        check(tag, int'(gc_share), exp);
        check({tag, " host"}, int'(host_share), 100 - exp);
        upd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        check("R1 reset gc", int'(gc_share), 50);
        check("R1 reset host", int'(host_share), 50);
        rst = 1'b0;

        // R7: inputs move without a strobe
        cur_tag = "R7";
        drive(1'b0, 0, 5000);
        drive(1'b0, 300, 10);
        expect_gc("R7 hold at reset split", 50);

        // R3: plentiful and equal
        cur_tag = "R3";
        drive(1'b1, 200, 100);
        expect_gc("R3 plentiful", 20);
        drive(1'b1, 77, 77);
        expect_gc("R3 equal", 20);

        // R4: linear region
        cur_tag = "R4";
        drive(1'b1, 100, 105);
        expect_gc("R4 deficit 5", 40);
        drive(1'b1, 9, 10);
        expect_gc("R4 deficit 1", 24);
        drive(1'b1, 0, 17);
        expect_gc("R4 deficit 17", 88);

        // R5: clamp
        cur_tag = "R5";
        drive(1'b1, 0, 18);
        expect_gc("R5 deficit 18", 90);
        drive(1'b1, 0, 65535);
        expect_gc("R5 max deficit", 90);
        drive(1'b1, 1, 16385);
        expect_gc("R5 wrap-prone deficit", 90);

        // R8: old value stands until the edge
        cur_tag = "R8";
        drive(1'b1, 10, 20);
        #1;
        check("R8 before edge", int'(gc_share), 90);
        expect_gc("R8 after edge", 60);

        // R7: hold after a strobe
        cur_tag = "R7";
        drive(1'b0, 0, 60000);
        drive(1'b0, 500, 0);
        expect_gc("R7 hold after load", 60);

        // R9: monotonic sweep
        cur_tag = "R9";
        begin
            int prev = 0;
            for (int d = 0; d <= 25; d++) begin
                drive(1'b1, 1000, 1000 + d);
                @(negedge clk);
                upd_stb = 1'b0;
                check("R9 non-decreasing", int'(int'(gc_share) >= prev), 1);
                prev = int'(gc_share);
            end
        end

        // R1: reset mid-run
        cur_tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        upd_stb = 1'b1;
        free_cnt = 16'd0;
        target_cnt = 16'd3;
        expect_gc("R1 reset mid-run", 50);
        rst = 1'b0;
        expect_gc("R1 stays after reset", 50);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule